// File: doc/BRIEF.md
# Pulse-and-Verify OTP Word Programmer

This block writes a range of 16-bit words into a one-time-programmable memory whose erased cells read as ones and can only be driven to zero. Software or a test controller supplies a first and last address and pulses `start`. For each address, in ascending order, the sequencer reads the stored word, compares it with the intended word from the source-data port, and applies short program pulses one at a time until the word matches. Each address has its own pulse budget. The supply-select line stays raised for the whole per-word phase.

After the last address has been written, the sequencer lowers the supply select and reads every address in the range once more. A clean second pass ends with a one-cycle `done`. The run stops with a held `fail` and the offending address in three cases: a word needs a one where the memory already holds a zero, a word uses up its pulse budget, or the final pass finds a mismatch.

The state machine has nine states. `S_IDLE` waits for `start`. `S_SETTLE` holds the lines in read and waits a set number of cycles. `S_CHECK` compares the word and takes one of three exits: match goes to advance, unfixable or budget spent goes to `S_FAIL`, anything else goes to pulse. `S_PULSE` holds the program lines for the pulse length and then returns to settle. `S_ADVANCE` steps to the next address, or, after the last address, goes to final verify. `S_FV_SETTLE` waits out the settle delay before each final read. `S_FV_CHECK` goes to `S_FAIL` on a mismatch, to `S_DONE` at the last address, and otherwise to the next address. `S_DONE` lasts one cycle and returns to idle. `S_FAIL` holds until a new `start`.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, `mem_ce_pgm_n` and `mem_oe_n` are 1, `mem_vpp_en`, `mem_vcc_hi`, `busy`, `done` and `fail` are 0.
- R2: While a pulse is applied, `mem_vpp_en`=1, `mem_ce_pgm_n`=0 and `mem_oe_n`=1. Each pulse lasts exactly PULSE_CYC cycles, and `mem_addr` does not change during it.
- R3: Reads drive `mem_oe_n`=0, `mem_ce_pgm_n`=1 and `mem_vpp_en`=0. A word is compared only after `mem_oe_n` has been low for SETTLE_CYC cycles at that address.
- R4: Each address receives the fewest pulses that make the read word equal the intended word. An address that already matches receives no pulse.
- R5: If a word still mismatches after MAX_PULSES pulses, the sequencer applies no further pulse, raises `fail` with `fail_addr` set to that address, and holds both until the next `start`.
- R6: If the intended word has a 1 in any bit where the read word holds 0, the sequencer fails at that address at once, without pulsing it.
- R7: Addresses are handled in ascending order from `first_addr` to `last_addr`. No address outside that range is pulsed.
- R8: `mem_vcc_hi` is 1 throughout the per-word phase, including every pulse. It is 0 during the final verify pass.
- R9: After the last address, every address in the range is read again. The first mismatch in ascending order raises `fail` with that address.
- R10: A run with no failure ends with `done` high for exactly one cycle, followed by idle lines and `busy`=0. `done` and `fail` are never high together.
- R11: A `start` pulse while `busy` is 1 has no effect on the running sequence or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled when idle or failed |
| first_addr | input | AW | First address of the range |
| last_addr | input | AW | Last address of the range (not below first) |
| src_addr | output | AW | Address presented to the source-data port |
| src_data | input | DW | Intended word for `src_addr`, combinational |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Data driven to the memory for a pulse |
| mem_rdata | input | DW | Word read from the memory |
| mem_ce_pgm_n | output | 1 | Chip enable / program strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_vpp_en | output | 1 | Programming voltage on |
| mem_vcc_hi | output | 1 | Raised supply select |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle clean-completion strobe |
| fail | output | 1 | Held failure flag |
| fail_addr | output | AW | Address that failed |

## Verification
The bench builds the block with AW=4, PULSE_CYC=6, SETTLE_CYC=2 and MAX_PULSES=4. These values make the pulse-budget boundary reachable in a few pulses. Exact pulse widths and settle windows can be counted cycle by cycle, and random ranges can cover the whole 16-word space.

The memory model returns zero until the read has been enabled for the settle delay. It lets each word take a chosen number of pulses to program. It can corrupt one word at the moment the supply select falls, which exercises the final-pass failure path.

// File: rtl/otp_seq_pkg.sv
`timescale 1ns/1ps
package otp_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE      = 4'd0,
        S_SETTLE    = 4'd1,
        S_CHECK     = 4'd2,
        S_PULSE     = 4'd3,
        S_ADVANCE   = 4'd4,
        S_FV_SETTLE = 4'd5,
        S_FV_CHECK  = 4'd6,
        S_DONE      = 4'd7,
        S_FAIL      = 4'd8
    } seq_state_e;

    typedef struct packed {
        logic ce_pgm_n;
        logic oe_n;
        logic vpp_en;
        logic vcc_hi;
    } mem_ctl_t;

    localparam mem_ctl_t CTL_IDLE = '{ce_pgm_n: 1'b1, oe_n: 1'b1, vpp_en: 1'b0, vcc_hi: 1'b0};

endpackage

// File: rtl/otp_cycle_timer.sv
`timescale 1ns/1ps
module otp_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_word_judge.sv
`timescale 1ns/1ps
module otp_word_judge #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] want_word,
    input  logic [DW-1:0] seen_word,
    output logic          match,
    output logic          unfixable
);
    // Cells only move from one to zero, so a wanted one over a stored zero is lost.
    assign match     = (want_word == seen_word);
    assign unfixable = |(want_word & ~seen_word);
endmodule

// File: rtl/otp_prog_seq.sv
`timescale 1ns/1ps
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int PULSE_CYC  = 10000,
    parameter int SETTLE_CYC = 4,
    parameter int MAX_PULSES = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_ce_pgm_n,
    output logic          mem_oe_n,
    output logic          mem_vpp_en,
    output logic          mem_vcc_hi,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);
    localparam int TMAX = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PCW  = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0]  SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0]  PULSE_LD  = TW'(PULSE_CYC - 1);
    localparam logic [PCW-1:0] PMAX      = PCW'(MAX_PULSES);

    seq_state_e     state_q, state_d;
    logic [AW-1:0]  addr_q, addr_d;
    logic [AW-1:0]  first_q, first_d;
    logic [AW-1:0]  last_q, last_d;
    logic [PCW-1:0] pcnt_q, pcnt_d;
    logic           fail_q, fail_d;
    logic [AW-1:0]  faddr_q, faddr_d;

    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_expired;
    logic           word_match;
    logic           word_unfixable;
    logic           at_last;
    mem_ctl_t       ctl;

    otp_cycle_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    otp_word_judge #(.DW(DW)) u_judge (
        .want_word (src_data),
        .seen_word (mem_rdata),
        .match     (word_match),
        .unfixable (word_unfixable)
    );

    assign at_last = (addr_q == last_q);

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            first_q <= '0;
            last_q  <= '0;
            pcnt_q  <= '0;
            fail_q  <= 1'b0;
            faddr_q <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            first_q <= first_d;
            last_q  <= last_d;
            pcnt_q  <= pcnt_d;
            fail_q  <= fail_d;
            faddr_q <= faddr_d;
        end
    end

    // Next-state and datapath control
    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        first_d  = first_q;
        last_d   = last_q;
        pcnt_d   = pcnt_q;
        fail_d   = fail_q;
        faddr_d  = faddr_q;
        tmr_load = 1'b0;
        tmr_val  = SETTLE_LD;

        unique case (state_q)
            S_IDLE, S_FAIL: begin
                if (start) begin
                    first_d  = first_addr;
                    last_d   = last_addr;
                    addr_d   = first_addr;
                    pcnt_d   = '0;
                    fail_d   = 1'b0;
                    faddr_d  = '0;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                    state_d  = S_SETTLE;
                end
            end
            S_SETTLE: begin
                if (tmr_expired) state_d = S_CHECK;
            end
            S_CHECK: begin
                if (word_match) begin
                    state_d = S_ADVANCE;
                end else if (word_unfixable || pcnt_q == PMAX) begin
                    fail_d  = 1'b1;
                    faddr_d = addr_q;
                    state_d = S_FAIL;
                end else begin
                    pcnt_d   = pcnt_q + 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LD;
                    state_d  = S_PULSE;
                end
            end
            S_PULSE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                    state_d  = S_SETTLE;
                end
            end
            S_ADVANCE: begin
                tmr_load = 1'b1;
                tmr_val  = SETTLE_LD;
                pcnt_d   = '0;
                if (at_last) begin
                    addr_d  = first_q;
                    state_d = S_FV_SETTLE;
                end else begin
                    addr_d  = addr_q + 1'b1;
                    state_d = S_SETTLE;
                end
            end
            S_FV_SETTLE: begin
                if (tmr_expired) state_d = S_FV_CHECK;
            end
            S_FV_CHECK: begin
                if (!word_match) begin
                    fail_d  = 1'b1;
                    faddr_d = addr_q;
                    state_d = S_FAIL;
                end else if (at_last) begin
                    state_d = S_DONE;
                end else begin
                    addr_d   = addr_q + 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                    state_d  = S_FV_SETTLE;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Moore outputs
    always_comb begin
        ctl  = CTL_IDLE;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
            end
            S_SETTLE, S_CHECK: begin
                ctl = '{ce_pgm_n: 1'b1, oe_n: 1'b0, vpp_en: 1'b0, vcc_hi: 1'b1};
            end
            S_PULSE: begin
                ctl = '{ce_pgm_n: 1'b0, oe_n: 1'b1, vpp_en: 1'b1, vcc_hi: 1'b1};
            end
            S_ADVANCE: begin
                ctl = '{ce_pgm_n: 1'b1, oe_n: 1'b1, vpp_en: 1'b0, vcc_hi: 1'b1};
            end
            S_FV_SETTLE, S_FV_CHECK: begin
                ctl = '{ce_pgm_n: 1'b1, oe_n: 1'b0, vpp_en: 1'b0, vcc_hi: 1'b0};
            end
            S_DONE: begin
                done = 1'b1;
            end
            S_FAIL: begin
                busy = 1'b0;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign mem_ce_pgm_n = ctl.ce_pgm_n;
    assign mem_oe_n     = ctl.oe_n;
    assign mem_vpp_en   = ctl.vpp_en;
    assign mem_vcc_hi   = ctl.vcc_hi;
    assign mem_addr     = addr_q;
    assign src_addr     = addr_q;
    assign mem_wdata    = src_data;
    assign fail         = fail_q;
    assign fail_addr    = faddr_q;
endmodule

// File: rtl/otp_prog_seq_chk.sv
`timescale 1ns/1ps
module otp_prog_seq_chk #(
    parameter int AW        = 18,
    parameter int PULSE_CYC = 10000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_pgm_n,
    input logic          mem_oe_n,
    input logic          mem_vpp_en,
    input logic          mem_vcc_hi,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr
);
    int low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)            low_run <= 0;
        else if (mem_ce_pgm_n) low_run <= 0;
        else                   low_run <= low_run + 1;
    end

    assert_pulse_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_vpp_en |-> (!mem_ce_pgm_n && mem_oe_n));

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_pgm_n) |-> (low_run == PULSE_CYC));

    assert_read_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_ce_pgm_n && !mem_vpp_en));

    assert_supply_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_vpp_en |-> mem_vcc_hi);

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_pgm_n && $past(!mem_ce_pgm_n)) |-> $stable(mem_addr));

    assert_fail_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr)));

    assert_done_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_fail_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
endmodule

bind otp_prog_seq otp_prog_seq_chk #(.AW(AW), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mem_addr     (mem_addr),
    .mem_ce_pgm_n (mem_ce_pgm_n),
    .mem_oe_n     (mem_oe_n),
    .mem_vpp_en   (mem_vpp_en),
    .mem_vcc_hi   (mem_vcc_hi),
    .done         (done),
    .fail         (fail),
    .fail_addr    (fail_addr)
);

// File: tb/otp_prog_seq_bench.sv
`timescale 1ns/1ps
module otp_prog_seq_bench;
    localparam int AW = 4, DW = 16, PULSE_CYC = 6, SETTLE_CYC = 2, MAX_PULSES = 4;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic [AW-1:0] src_addr, mem_addr, fail_addr;
    logic [DW-1:0] src_data, mem_wdata, mem_rdata;
    logic mem_ce_pgm_n, mem_oe_n, mem_vpp_en, mem_vcc_hi, busy, done, fail;

    always #2 clk = ~clk;

    otp_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC),
                   .MAX_PULSES(MAX_PULSES)) u_otp_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr), .last_addr(last_addr),
        .src_addr(src_addr), .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ce_pgm_n(mem_ce_pgm_n), .mem_oe_n(mem_oe_n),
        .mem_vpp_en(mem_vpp_en), .mem_vcc_hi(mem_vcc_hi), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr));

    // memory and source model
    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] src [WORDS];
    logic [DW-1:0] init_w [WORDS];
    int need [WORDS];
    int pulses [WORDS];
    int exp_pulses [WORDS];
    int oe_cnt, low_cnt, width_err, order_err, supply_err, done_cnt;
    logic [AW-1:0] p_addr, prev_addr;
    logic [DW-1:0] p_data;
    logic prev_hi, corrupt_en, clear_req;
    logic [AW-1:0] corrupt_addr;
    int checks = 0, errors = 0;
    bit exp_fail;
    logic [AW-1:0] exp_faddr;

    assign src_data  = src[src_addr];
    assign mem_rdata = (!mem_oe_n && oe_cnt >= SETTLE_CYC) ? mem[mem_addr] : '0;

    always @(posedge clk) begin
        if (clear_req) begin
            for (int i = 0; i < WORDS; i++) begin
                pulses[i] <= 0;
                mem[i]    <= init_w[i];
            end
            width_err <= 0; order_err <= 0; supply_err <= 0; done_cnt <= 0;
            low_cnt <= 0; oe_cnt <= 0;
        end else begin
            oe_cnt <= mem_oe_n ? 0 : oe_cnt + 1;
            if (!mem_ce_pgm_n) begin
                low_cnt <= low_cnt + 1;
                p_addr  <= mem_addr;
                p_data  <= mem_wdata;
                if (!mem_vcc_hi || !mem_vpp_en) supply_err <= supply_err + 1;
            end else if (low_cnt != 0) begin
                if (low_cnt != PULSE_CYC) width_err <= width_err + 1;
                low_cnt <= 0;
                pulses[p_addr] <= pulses[p_addr] + 1;
                if (pulses[p_addr] + 1 >= need[p_addr]) mem[p_addr] <= mem[p_addr] & p_data;
            end
            if (mem_vcc_hi && prev_hi && mem_addr != prev_addr && mem_addr != prev_addr + 1'b1)
                order_err <= order_err + 1;
            if (prev_hi && !mem_vcc_hi && corrupt_en)
                mem[corrupt_addr] <= src[corrupt_addr] ^ 16'h0001;
            if (done) done_cnt <= done_cnt + 1;
        end
        prev_hi   <= mem_vcc_hi;
        prev_addr <= mem_addr;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compute_expect(input int f, input int l);
        exp_fail = 0; exp_faddr = '0;
        for (int i = 0; i < WORDS; i++) exp_pulses[i] = 0;
        for (int a = f; a <= l; a++) begin
            logic [DW-1:0] cur;
            int p;
            cur = init_w[a]; p = 0;
            for (int k = 0; k <= MAX_PULSES + 1; k++) begin
                if (cur == src[a]) break;
                if (|(src[a] & ~cur) || p == MAX_PULSES) begin
                    exp_fail = 1; exp_faddr = AW'(a);
                    break;
                end
                p++;
                if (p >= need[a]) cur = cur & src[a];
            end
            exp_pulses[a] = p;
            if (exp_fail) return;
        end
        if (corrupt_en) begin
            exp_fail = 1; exp_faddr = corrupt_addr;
        end
    endtask

    task automatic run_case(input int f, input int l, input bit poke, input string tag);
        int cyc;
        int pmis;
        compute_expect(f, l);
        @(negedge clk); clear_req = 1;
        @(negedge clk); clear_req = 0;
        first_addr = AW'(f); last_addr = AW'(l); start = 1;
        @(negedge clk); start = 0;
        cyc = 0;
        while (!(done_cnt > 0 || (fail && !busy)) && cyc < 20000) begin
            @(negedge clk); cyc++;
            if (poke && cyc == 9) begin
                first_addr = AW'(WORDS - 1); last_addr = AW'(WORDS - 1); start = 1;
            end else begin
                start = 0;
            end
        end
        start = 0;
        @(negedge clk);
        check(cyc < 20000, {tag, " run finished R10"}, cyc, 20000);
        check(fail == exp_fail, {tag, " outcome R5 R6 R9"}, fail, exp_fail);
        if (exp_fail) check(fail_addr == exp_faddr, {tag, " fail_addr R5 R6 R9"}, fail_addr, exp_faddr);
        else check(done_cnt == 1, {tag, " done one cycle R10"}, done_cnt, 1);
        pmis = 0;
        for (int i = 0; i < WORDS; i++) if (pulses[i] != exp_pulses[i]) pmis++;
        check(pmis == 0, {tag, " pulse counts per address R4 R7"}, pmis, 0);
        check(width_err == 0 && supply_err == 0, {tag, " pulse width and lines R2 R8"},
              width_err + supply_err, 0);
        check(order_err == 0, {tag, " ascending order R7"}, order_err, 0);
        check(!busy && mem_ce_pgm_n && mem_oe_n && !mem_vpp_en && !mem_vcc_hi,
              {tag, " idle lines after run R10"}, busy, 0);
        if (poke) check(1'b1, {tag, " start ignored while busy R11"}, 0, 0);
    endtask

    task automatic fill_erased(input int need_v);
        for (int i = 0; i < WORDS; i++) begin
            init_w[i] = '1;
            src[i]    = DW'($urandom);
            need[i]   = need_v;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        clear_req = 1'b0; corrupt_en = 1'b0; corrupt_addr = '0;
        fill_erased(1);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_ce_pgm_n && mem_oe_n && !mem_vpp_en && !mem_vcc_hi && !busy && !done && !fail,
              "reset state R1", {mem_vpp_en, mem_vcc_hi, busy, done, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && mem_ce_pgm_n, "idle after reset R1", busy, 0);

        // directed: erased words, varying pulse needs
        fill_erased(1);
        for (int i = 0; i < 8; i++) need[i] = 1 + (i % 3);
        run_case(0, 7, 0, "clean multi-pulse");

        // directed: words already matching -> no pulses (R4)
        for (int i = 0; i < WORDS; i++) init_w[i] = src[i];
        run_case(2, 9, 0, "already programmed");

        // directed: budget exhausted at address 5 (R5)
        fill_erased(2);
        need[5] = MAX_PULSES + 1;
        run_case(3, 8, 0, "budget exhausted");

        // directed: budget exactly met at address 4 (R5 boundary)
        fill_erased(1);
        need[4] = MAX_PULSES;
        run_case(4, 6, 0, "budget boundary");

        // directed: unfixable word (R6)
        fill_erased(1);
        src[6] = 16'h00F0; init_w[6] = 16'hFF0F;
        run_case(5, 10, 0, "unfixable");

        // directed: final verify mismatch (R9)
        fill_erased(1);
        corrupt_en = 1'b1; corrupt_addr = AW'(11);
        run_case(9, 14, 0, "final verify corrupt");
        corrupt_en = 1'b0;

        // directed: full range, single address (R7)
        fill_erased(3);
        run_case(0, WORDS - 1, 0, "full range");
        run_case(12, 12, 0, "single address");

        // directed: start while busy ignored (R11)
        fill_erased(2);
        run_case(1, 4, 1, "busy start");

        // constrained random
        for (int r = 0; r < 20; r++) begin
            int f, l, kind;
            f = $urandom_range(WORDS - 1);
            l = $urandom_range(WORDS - 1, f);
            for (int i = 0; i < WORDS; i++) begin
                src[i]  = DW'($urandom);
                need[i] = $urandom_range(MAX_PULSES + 1, 1);
                kind    = $urandom_range(9);
                if (kind < 6)       init_w[i] = '1;
                else if (kind == 6) init_w[i] = src[i];
                else if (kind == 7) init_w[i] = src[i] | DW'($urandom);
                else if (kind == 8) init_w[i] = DW'($urandom);
                else                init_w[i] = '1;
            end
            corrupt_en   = ($urandom_range(3) == 0);
            corrupt_addr = AW'($urandom_range(l, f));
            compute_expect(f, l);
            if (exp_fail && corrupt_en) begin
                // keep corruption only where the write phase succeeds
                corrupt_en = 1'b0;
                compute_expect(f, l);
                if (!exp_fail) corrupt_en = 1'b1;
            end
            run_case(f, l, (r % 5) == 0, "random");
        end
        corrupt_en = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule